// File: doc/BRIEF.md
# Buffered Page Write Committer

This block sits behind a two-wire memory slave and turns the data phase of a write transaction into array writes. Bytes arriving from the bus front end are parked in a small page buffer, and nothing reaches the array until the bus reports the stop condition. The buffer has one slot for each byte of a 16-byte page. The first byte of a transaction lands at the low address nibble supplied with it. Every later byte lands one slot further on. The slot index wraps inside the page, and the upper address bits, latched with the first byte, never move.

When stop arrives with at least one byte buffered, the block raises `busy` for a fixed number of system-clock cycles, which models the self-timed programming period. While `busy` is high the bus front end is locked out: byte strobes and stop strobes are ignored. In the first cycles of that window the block walks the buffer in ascending slot order. It issues one array write per slot that received a byte, so untouched bytes of the page keep their old contents. When the window closes, the buffer is emptied and the next transaction starts fresh.

Top module: `page_commit_ctrl`

## Requirements
- R1: After synchronous reset, `busy` and `arr_we` are both 0.
- R2: The first byte of a transaction is stored at slot `col_in`, and `row_in` is latched with it. When committed, its write address is `{row, slot}`: the row occupies the upper 6 bits and the slot the low 4 bits of `arr_addr`.
- R3: Each further byte of the same transaction goes to the previous slot plus one, modulo 16. The inputs `col_in` and `row_in` presented with these later bytes are ignored.
- R4: If more than 16 bytes arrive before stop, the slot index wraps around and later bytes overwrite earlier ones. Only the last value written to a slot is committed.
- R5: A stop strobe with at least one buffered byte makes `busy` 1 from the next cycle on, and `busy` stays 1 for exactly WR_CYCLES cycles.
- R6: During the busy window, slot k is examined in the (k+1)-th busy cycle. `arr_we` pulses for one cycle for each slot that received a byte, in ascending slot order, and no other slot is written.
- R7: While `busy` is 1, `byte_vld` and `stop_in` have no effect. Such bytes are never committed, and such a stop does not lengthen the window.
- R8: A stop strobe with no buffered byte leaves `busy` at 0 and causes no array write.
- R9: When the busy window ends, the record of filled slots is cleared, so the next commit writes only the bytes of its own transaction.
- R10: `arr_we` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: a data byte was received |
| byte_data | input | 8 | Received data byte |
| col_in | input | 4 | Starting slot, used with the first byte only |
| row_in | input | 6 | Page row address, latched with the first byte |
| stop_in | input | 1 | One-cycle strobe: stop condition seen on the bus |
| arr_we | output | 1 | Array write enable, one cycle per byte |
| arr_addr | output | 10 | Array write address {row, slot} |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Write window active; bus input locked out |

## Verification
Every strobe is driven on a falling edge and taken on the next rising edge. `busy` is therefore due at the first falling edge after the stop strobe. The write for slot k appears at the (k+1)-th falling edge of the busy window. The stop task pushes the expected writes into the scoreboard queue, in ascending slot order, before the edge that starts the window. A falling-edge monitor pops one entry for each `arr_we` it sees. When `busy` drops, the monitor compares the length of the window with WR_CYCLES and requires the queue to be empty, so a write that is late, missing or extra is reported.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int BYTE_W = 8;
    localparam int COL_W  = 4;
    localparam int ROW_W  = 6;
    localparam int SLOTS  = 1 << COL_W;
    localparam int ADDR_W = ROW_W + COL_W;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        row_t row;
        col_t col;
    } arr_addr_t;

    typedef struct packed {
        logic      we;
        arr_addr_t addr;
        byte_t     data;
    } arr_wr_t;

    // Next slot inside the page; natural wrap at the column width.
    function automatic col_t next_col(input col_t c);
        return c + col_t'(1);
    endfunction
endpackage

// File: rtl/pgw_buffer.sv
module pgw_buffer
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  byte_t             wr_data,
    input  col_t              start_col,
    input  row_t              start_row,
    input  logic              clr,
    input  col_t              rd_idx,
    output byte_t             rd_data,
    output logic              rd_full,
    output logic [SLOTS-1:0]  mask_o,
    output row_t              row_o
);
    byte_t              mem_q [SLOTS];
    logic [SLOTS-1:0]   mask_q;
    col_t               ptr_q;
    row_t               row_q;
    col_t               pos;
    logic               first;

    assign first = (mask_q == '0);
    assign pos   = first ? start_col : next_col(ptr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            row_q <= '0;
        end else if (wr_en) begin
            ptr_q <= pos;
            if (first) row_q <= start_row;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[i] <= 1'b0;
            end else if (clr) begin
                mask_q[i] <= 1'b0;
            end else if (wr_en && pos == col_t'(i)) begin
                mask_q[i] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_en && pos == col_t'(i)) mem_q[i] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
    assign rd_full = mask_q[rd_idx];
    assign mask_o  = mask_q;
    assign row_o   = row_q;

    // The slot just written is marked filled.
    p_slot_marked_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && !clr |=> mask_q[ptr_q]);
    // Row stays put once a transaction has started.
    p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mask_q != '0) && !clr |=> $stable(row_q));
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer
    import pgw_pkg::*;
#(
    parameter int WR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic scan_act,
    output col_t scan_idx,
    output logic done
);
    localparam int CNT_W = $clog2(WR_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy     = busy_q;
    assign done     = busy_q && (cnt_q == LAST);
    assign scan_act = busy_q && (int'(cnt_q) < SLOTS);
    assign scan_idx = cnt_q[COL_W-1:0];

    p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> cnt_q == '0);
    p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pgw_pkg::*;
#(
    parameter int WR_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [COL_W-1:0]  col_in,
    input  logic [ROW_W-1:0]  row_in,
    input  logic              stop_in,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [BYTE_W-1:0] arr_data,
    output logic              busy
);
    logic              busy_w, scan_act, done, rd_full, go, wr_en;
    col_t              scan_idx;
    byte_t             rd_data;
    logic [SLOTS-1:0]  mask_w;
    row_t              row_w;
    arr_wr_t           wr;

    assign wr_en = byte_vld && !busy_w;
    assign go    = stop_in && !busy_w && (mask_w != '0);

    pgw_buffer u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (byte_data),
        .start_col (col_in),
        .start_row (row_in),
        .clr       (done),
        .rd_idx    (scan_idx),
        .rd_data   (rd_data),
        .rd_full   (rd_full),
        .mask_o    (mask_w),
        .row_o     (row_w)
    );

    pgw_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .busy     (busy_w),
        .scan_act (scan_act),
        .scan_idx (scan_idx),
        .done     (done)
    );

    always_comb begin
        wr.we       = scan_act && rd_full;
        wr.addr.row = row_w;
        wr.addr.col = scan_idx;
        wr.data     = rd_data;
    end

    assign arr_we   = wr.we;
    assign arr_addr = wr.addr;
    assign arr_data = wr.data;
    assign busy     = busy_w;

    p_we_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);
    p_empty_stop_r8: assert property (@(posedge clk) disable iff (rst)
        stop_in && !busy && (mask_w == '0) |=> !busy);
    p_locked_r7: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> $stable(mask_w));
    p_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> mask_w == '0);
    p_start_r5: assert property (@(posedge clk) disable iff (rst)
        stop_in && !busy && (mask_w != '0) |=> busy);
endmodule

// File: tb/tb_page_commit_ctrl.sv
module tb_page_commit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WR = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic [3:0] col_in = '0;
    logic [5:0] row_in = '0;
    logic       stop_in = 1'b0;
    logic       arr_we;
    logic [9:0] arr_addr;
    logic [7:0] arr_data;
    logic       busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int blen = 0;

    logic [17:0] sb_q[$];
    logic [7:0]  m_data [16];
    logic [15:0] m_mask = '0;
    logic [3:0]  m_ptr = '0;
    logic [5:0]  m_row = '0;

    page_commit_ctrl #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .col_in(col_in), .row_in(row_in), .stop_in(stop_in),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: one queue entry per array write, window length on busy fall.
    always @(negedge clk) begin
        if (!rst) begin
            if (arr_we) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected write", int'({arr_addr, arr_data}), 0);
                end else begin
                    logic [17:0] e;
                    e = sb_q.pop_front();
                    chk({arr_addr, arr_data} == e, "R2/R3/R4/R6 write",
                        int'({arr_addr, arr_data}), int'(e));
                end
            end
            if (busy) blen++;
            else if (blen != 0) begin
                chk(blen == WR, "R5 busy length", blen, WR);
                chk(sb_q.size() == 0, "R6 missing writes", sb_q.size(), 0);
                blen = 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "watchdog", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] d, input logic [3:0] c, input logic [5:0] r);
        logic [3:0] p;
        @(negedge clk);
        byte_vld = 1'b1; byte_data = d; col_in = c; row_in = r;
        p = (m_mask == '0) ? c : m_ptr + 4'd1;
        if (m_mask == '0) m_row = r;
        m_data[p] = d;
        m_mask[p] = 1'b1;
        m_ptr = p;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic send_stop();
        bit had;
        @(negedge clk);
        had = (m_mask != '0);
        for (int k = 0; k < 16; k++)
            if (m_mask[k]) sb_q.push_back({m_row, 4'(k), m_data[k]});
        stop_in = 1'b1;
        @(negedge clk);
        stop_in = 1'b0;
        if (had) chk(busy == 1'b1, "R5 busy after stop", busy, 1);
        else     chk(busy == 1'b0, "R8 empty stop no busy", busy, 0);
        m_mask = '0;
    endtask

    // Strobes during the window: the model ignores them (R7).
    task automatic poke_locked(input logic [7:0] d);
        @(negedge clk);
        byte_vld = 1'b1; byte_data = d; col_in = 4'd7; stop_in = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; stop_in = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(arr_we == 1'b0, "R1 we after reset", arr_we, 0);

        // R2: single byte at slot 3, row 5
        send_byte(8'hA5, 4'd3, 6'h05);
        send_stop();
        wait_idle();

        // R3: wrap from slot 14; later col/row inputs ignored; R9 slot 3 not rewritten
        send_byte(8'h10, 4'd14, 6'h2A);
        send_byte(8'h11, 4'd2, 6'h01);
        send_byte(8'h12, 4'd9, 6'h02);
        send_byte(8'h13, 4'd0, 6'h03);
        send_byte(8'h14, 4'd5, 6'h04);
        send_stop();
        wait_idle();

        // R4: 20 bytes from slot 0 overwrite slots 0..3
        for (int i = 0; i < 20; i++) send_byte(8'(8'h40 + i), 4'd0, 6'h3F);
        send_stop();
        wait_idle();

        // R8: stop with nothing buffered
        send_stop();
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R8 still idle", busy, 0);
        chk(sb_q.size() == 0, "R8 no writes", sb_q.size(), 0);

        // R7: strobes while busy are ignored; R9 next commit holds only its own byte
        send_byte(8'h77, 4'd1, 6'h11);
        send_stop();
        poke_locked(8'hEE);
        repeat (WR/2) @(negedge clk);
        poke_locked(8'hDD);
        wait_idle();
        send_byte(8'h99, 4'd9, 6'h22);
        send_stop();
        wait_idle();
        chk(busy == 1'b0, "R5 window closed", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule